// File: doc/BRIEF.md
# Address-Half Privilege Checker

This block checks each linear-address memory request before any translation step. It decides whether the access is allowed, dropped silently, or faulted. The privilege of an address comes from its most significant bit alone. Addresses with the top bit clear are treated as belonging to user code. Addresses with the top bit set are treated as belonging to the supervisor. Because no page-table walk is involved, the time taken to reject a probe reveals nothing about how the tables are laid out.

The request carries the following information:

- the linear address;
- whether the access is an instruction fetch or a data access;
- the current privilege level (CPL);
- flags for an implicit system-structure access, a stack access, a non-faulting access (prefetch, cache demote or speculative) and a short 32/16-bit address.

Control inputs select:

- whether the separation check is enabled;
- whether long mode is active;
- whether the supervisor data guard is on;
- the alignment-check flag;
- the paging depth: 4-level or 5-level.

The block also runs a canonical-form check. It folds both kinds of violation into one prioritized fault code. The result appears one cycle after the request.

Top module: `half_split_guard`

## Requirements
- R1: After reset all outputs are 0. `rsp_valid` equals `req_valid` of the previous cycle. When `rsp_valid` is 1, exactly one of three things holds: `rsp_allow` is 1, `rsp_drop` is 1, or `rsp_fault` is nonzero. When `rsp_valid` is 0, `rsp_allow`, `rsp_drop`, `rsp_fault` and `rsp_split` are all 0.
- R2: With `cfg_long` at 0, every request is allowed, whatever the other inputs are.
- R3: In long mode a non-short address must be canonical, otherwise the request is a canonical violation (`rsp_split`=0). With `cfg_five_level`=0, address bits 63..47 must all be equal. With `cfg_five_level`=1, bits 63..56 must all be equal. This check applies whether or not the separation check is enabled.
- R4: With `cfg_enable`=0, the only violation that can be raised is a canonical one. Every other access is allowed.
- R5: A fetch is user-mode when the CPL is 3. A user-mode fetch violates when the effective top bit is 1.
- R6: A fetch at a CPL below 3 violates when the effective top bit is 0. This holds regardless of `cfg_data_guard` and `cfg_ac`.
- R7: A data access is user-mode only when the CPL is 3 and `req_sys` is 0. Otherwise it is supervisor-mode. A user-mode data access violates when the effective top bit is 1.
- R8: A supervisor-mode data access whose effective top bit is 0 violates only when `cfg_data_guard` is 1 and either `cfg_ac` is 0 or `req_sys` is 1. A supervisor-mode data access whose top bit is 1 never raises a separation violation.
- R9: With `req_short` set, the effective top bit is 0 and the canonical check is skipped.
- R10: A violating request that is not non-faulting reports a fault code. The code is 2'b10 (stack fault) when `req_stack` is 1 and 2'b01 (general protection) otherwise. The code 2'b11 never appears.
- R11: A violating request with `req_nofault` set raises `rsp_drop` and fault code 00.
- R12: When a request is both non-canonical and a separation violation, the canonical cause wins and `rsp_split` is 0. `rsp_split` is 1 only when a drop or fault comes from separation alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Linear address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_cpl | input | CPL_W | Current privilege level |
| req_sys | input | 1 | Implicit system-structure access |
| req_stack | input | 1 | Stack access |
| req_nofault | input | 1 | Prefetch, cache demote or speculative access |
| req_short | input | 1 | 32-bit or 16-bit address |
| cfg_enable | input | 1 | Separation check enable |
| cfg_long | input | 1 | Long mode active |
| cfg_data_guard | input | 1 | Supervisor data guard for low-half addresses |
| cfg_ac | input | 1 | Alignment-check flag |
| cfg_five_level | input | 1 | 1 = 5-level paging depth for the canonical check |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 1 | Access may proceed |
| rsp_drop | output | 1 | Access is discarded without a fault |
| rsp_fault | output | 2 | 00 none, 01 general protection, 10 stack fault |
| rsp_split | output | 1 | Cause is separation rather than canonical form |

## Verification
The bench drives a sweep over eight addresses. Each address is canonical under one paging depth, under both depths, or under neither. For each address it covers every combination of access kind, CPL and flag, and compares each result with a model built from the requirements.

The sweep goes after the following mistakes, and shows what each would produce:

- A design that reads the real top bit of short addresses would fault 32-bit user accesses.
- A design that applied the data guard to fetches would let supervisor fetches run user code.
- A design that kept the separation check live outside long mode would fault legacy accesses.
- A design that ranked the two causes the wrong way round would set `rsp_split` on non-canonical addresses.

The bench also looks for supervisor data accesses that ignore the alignment-check exception for system structures, and for non-faulting accesses that still report a code.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_GP   = 2'b01,
      FLT_SS   = 2'b10
   } hsg_fault_e;

   typedef struct packed {
      logic       allow;
      logic       drop;
      hsg_fault_e fault;
      logic       split;
   } hsg_result_t;

   localparam hsg_result_t HSG_IDLE = '{allow: 1'b0, drop: 1'b0,
                                       fault: FLT_NONE, split: 1'b0};

endpackage

// File: rtl/hsg_canon_chk.sv
module hsg_canon_chk #(
   parameter int ADDR_W       = 64,
   parameter int VA4_MSB      = 47,
   parameter int VA5_MSB      = 56,
   parameter bit SUPPORT_5LVL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              five_level,
   input  logic              long_mode,
   input  logic              short_addr,
   output logic              canon_bad
);

   localparam int HI4_W = ADDR_W - VA4_MSB;
   localparam int HI5_W = ADDR_W - VA5_MSB;

   logic [HI4_W-1:0] hi4;
   logic             uni4;
   logic             uniform;

   assign hi4  = addr[ADDR_W-1:VA4_MSB];
   assign uni4 = (&hi4) | ~(|hi4);

   generate
      if (SUPPORT_5LVL) begin : g_five
         logic [HI5_W-1:0] hi5;
         logic             uni5;
         assign hi5     = addr[ADDR_W-1:VA5_MSB];
         assign uni5    = (&hi5) | ~(|hi5);
         assign uniform = five_level ? uni5 : uni4;
      end else begin : g_four
         assign uniform = uni4;
      end
   endgenerate

   assign canon_bad = long_mode & ~short_addr & ~uniform;

endmodule

// File: rtl/hsg_split_chk.sv
module hsg_split_chk #(
   parameter int ADDR_W   = 64,
   parameter int CPL_W    = 2,
   parameter int USER_LVL = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              fetch,
   input  logic [CPL_W-1:0]  cpl,
   input  logic              sys_access,
   input  logic              short_addr,
   input  logic              enable,
   input  logic              long_mode,
   input  logic              data_guard,
   input  logic              ac_flag,
   output logic              split_bad
);

   localparam logic [CPL_W-1:0] USER_CODE = CPL_W'(USER_LVL);

   logic top_hi;
   logic at_user_lvl;
   logic fetch_bad;
   logic user_data;
   logic data_bad;
   logic guard_hit;
   logic active;

   // short addresses behave as if the top bit were clear
   assign top_hi      = short_addr ? 1'b0 : addr[ADDR_W-1];
   assign at_user_lvl = (cpl == USER_CODE);
   assign active      = enable & long_mode;

   // fetch side: both halves are guarded, no extra control
   always_comb begin
      if (at_user_lvl) fetch_bad = top_hi;
      else             fetch_bad = ~top_hi;
   end

   // data side: system-structure accesses are always supervisor accesses
   assign user_data = at_user_lvl & ~sys_access;
   assign guard_hit = data_guard & (~ac_flag | sys_access);

   always_comb begin
      if (user_data) data_bad = top_hi;
      else           data_bad = ~top_hi & guard_hit;
   end

   assign split_bad = active & (fetch ? fetch_bad : data_bad);

endmodule

// File: rtl/hsg_resolve.sv
module hsg_resolve
   import hsg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        canon_bad,
   input  logic        split_bad,
   input  logic        stack_access,
   input  logic        nofault,
   output logic        out_valid,
   output hsg_result_t out_res
);

   hsg_result_t nxt;
   logic        any_bad;

   assign any_bad = canon_bad | split_bad;

   always_comb begin
      nxt = HSG_IDLE;
      if (in_valid) begin
         if (!any_bad) begin
            nxt.allow = 1'b1;
         end else begin
            // canonical form outranks the separation check
            nxt.split = ~canon_bad;
            if (nofault) nxt.drop  = 1'b1;
            else         nxt.fault = stack_access ? FLT_SS : FLT_GP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= HSG_IDLE;
      end else begin
         out_valid <= in_valid;
         out_res   <= nxt;
      end
   end

endmodule

// File: rtl/half_split_guard.sv
module half_split_guard
   import hsg_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int VA4_MSB      = 47,
   parameter int VA5_MSB      = 56,
   parameter bit SUPPORT_5LVL = 1'b1,
   parameter int CPL_W        = 2,
   parameter int USER_LVL     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_fetch,
   input  logic [CPL_W-1:0]  req_cpl,
   input  logic              req_sys,
   input  logic              req_stack,
   input  logic              req_nofault,
   input  logic              req_short,
   input  logic              cfg_enable,
   input  logic              cfg_long,
   input  logic              cfg_data_guard,
   input  logic              cfg_ac,
   input  logic              cfg_five_level,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic              rsp_drop,
   output logic [1:0]        rsp_fault,
   output logic              rsp_split
);

   localparam int MAX_CPL = (1 << CPL_W) - 1;

   generate
      if (VA4_MSB < 1 || VA4_MSB >= ADDR_W - 1) begin : g_bad_va4
         $error("VA4_MSB out of range");
      end
      if (SUPPORT_5LVL && (VA5_MSB <= VA4_MSB || VA5_MSB >= ADDR_W - 1)) begin : g_bad_va5
         $error("VA5_MSB must lie between VA4_MSB and the top bit");
      end
      if (USER_LVL < 1 || USER_LVL > MAX_CPL) begin : g_bad_lvl
         $error("USER_LVL does not fit CPL_W");
      end
   endgenerate

   logic        canon_bad;
   logic        split_bad;
   hsg_result_t res;

   hsg_canon_chk #(
      .ADDR_W      (ADDR_W),
      .VA4_MSB     (VA4_MSB),
      .VA5_MSB     (VA5_MSB),
      .SUPPORT_5LVL(SUPPORT_5LVL)
   ) u_canon (
      .addr      (req_addr),
      .five_level(cfg_five_level),
      .long_mode (cfg_long),
      .short_addr(req_short),
      .canon_bad (canon_bad)
   );

   hsg_split_chk #(
      .ADDR_W  (ADDR_W),
      .CPL_W   (CPL_W),
      .USER_LVL(USER_LVL)
   ) u_split (
      .addr      (req_addr),
      .fetch     (req_fetch),
      .cpl       (req_cpl),
      .sys_access(req_sys),
      .short_addr(req_short),
      .enable    (cfg_enable),
      .long_mode (cfg_long),
      .data_guard(cfg_data_guard),
      .ac_flag   (cfg_ac),
      .split_bad (split_bad)
   );

   hsg_resolve u_resolve (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (req_valid),
      .canon_bad   (canon_bad),
      .split_bad   (split_bad),
      .stack_access(req_stack),
      .nofault     (req_nofault),
      .out_valid   (rsp_valid),
      .out_res     (res)
   );

   assign rsp_allow = res.allow;
   assign rsp_drop  = res.drop;
   assign rsp_fault = res.fault;
   assign rsp_split = res.split;

endmodule

// File: rtl/hsg_checks.sv
module hsg_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_stack,
   input logic       req_nofault,
   input logic       cfg_enable,
   input logic       cfg_long,
   input logic       rsp_valid,
   input logic       rsp_allow,
   input logic       rsp_drop,
   input logic [1:0] rsp_fault,
   input logic       rsp_split
);

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R1
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_allow, rsp_drop, rsp_fault != 2'b00}) == 1);

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_allow && !rsp_drop && rsp_fault == 2'b00 && !rsp_split));

   // R2
   legacy_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_long) |=> rsp_allow);

   // R4
   off_canon_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_enable) |=> !rsp_split);

   // R10
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'b11);

   // R10
   stack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_stack && !req_nofault) |=> rsp_fault != 2'b01);

   // R11
   nofault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_nofault) |=> rsp_fault == 2'b00);

endmodule

bind half_split_guard hsg_checks u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_stack  (req_stack),
   .req_nofault(req_nofault),
   .cfg_enable (cfg_enable),
   .cfg_long   (cfg_long),
   .rsp_valid  (rsp_valid),
   .rsp_allow  (rsp_allow),
   .rsp_drop   (rsp_drop),
   .rsp_fault  (rsp_fault),
   .rsp_split  (rsp_split)
);

// File: tb/half_split_guard_tb.sv
module half_split_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        req_fetch = 1'b0;
   logic [1:0]  req_cpl = '0;
   logic        req_sys = 1'b0;
   logic        req_stack = 1'b0;
   logic        req_nofault = 1'b0;
   logic        req_short = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        cfg_long = 1'b0;
   logic        cfg_data_guard = 1'b0;
   logic        cfg_ac = 1'b0;
   logic        cfg_five_level = 1'b0;
   logic        rsp_valid;
   logic        rsp_allow;
   logic        rsp_drop;
   logic [1:0]  rsp_fault;
   logic        rsp_split;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   half_split_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_fetch(req_fetch), .req_cpl(req_cpl), .req_sys(req_sys),
      .req_stack(req_stack), .req_nofault(req_nofault), .req_short(req_short),
      .cfg_enable(cfg_enable), .cfg_long(cfg_long),
      .cfg_data_guard(cfg_data_guard), .cfg_ac(cfg_ac),
      .cfg_five_level(cfg_five_level), .rsp_valid(rsp_valid),
      .rsp_allow(rsp_allow), .rsp_drop(rsp_drop), .rsp_fault(rsp_fault),
      .rsp_split(rsp_split)
   );

   function automatic logic [63:0] pick_addr(input int i);
      case (i)
         0:       return 64'h0000_0000_0000_1000;  // low, canonical both
         1:       return 64'h0000_7FFF_FFFF_F000;  // low, canonical both
         2:       return 64'hFFFF_8000_0000_0000;  // high, canonical both
         3:       return 64'hFFFF_FFFF_FFFF_F000;  // high, canonical both
         4:       return 64'h0000_8000_0000_0000;  // bad 4-level only
         5:       return 64'hFF80_0000_0000_0000;  // bad 4-level only, high
         6:       return 64'h00FF_FFFF_FFFF_F000;  // bad 4-level only
         default: return 64'h8000_0000_0000_0000;  // bad at both depths
      endcase
   endfunction

   // expected {allow, drop, fault[1:0], split} and the deciding requirement
   function automatic logic [4:0] model(output string tag);
      logic [63:0] top4;
      logic [63:0] top5;
      logic        cbad;
      logic        sbad;
      logic        hi;
      logic        user;
      top4 = req_addr >> 47;
      top5 = req_addr >> 56;
      tag  = "R2";
      if (!cfg_long) return 5'b10000;
      if (req_short) cbad = 1'b0;                                   // R9
      else if (cfg_five_level) cbad = !(top5 == 64'h0 || top5 == 64'hFF);
      else cbad = !(top4 == 64'h0 || top4 == 64'h1FFFF);            // R3
      hi   = req_short ? 1'b0 : req_addr[63];
      sbad = 1'b0;
      if (cfg_enable) begin
         if (req_fetch) begin
            user = (req_cpl == 2'd3);
            sbad = user ? hi : !hi;                                 // R5 R6
            tag  = user ? "R5" : "R6";
         end else begin
            user = (req_cpl == 2'd3) && !req_sys;
            sbad = user ? hi : (!hi && cfg_data_guard && (!cfg_ac || req_sys));
            tag  = user ? "R7" : "R8";
         end
      end else begin
         tag = "R4";
      end
      if (req_short) tag = "R9";
      if (cbad) tag = sbad ? "R12" : "R3";
      if (!cbad && !sbad) return 5'b10000;
      if (req_nofault) begin
         if (!cbad) tag = "R11";
         return {2'b01, 2'b00, !cbad};
      end
      if (!cbad && req_stack) tag = "R10";
      return {2'b00, req_stack ? 2'b10 : 2'b01, !cbad};
   endfunction

   task automatic check(input string tag, input logic [5:0] exp);
      logic [5:0] got;
      got = {rsp_valid, rsp_allow, rsp_drop, rsp_fault, rsp_split};
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got v/allow/drop/fault/split=%b expected %b (addr=%h f=%0d cpl=%0d)",
                  tag, got, exp, req_addr, req_fetch, req_cpl);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      string       tag;
      logic [4:0]  e;
      logic [9:0]  f;
      repeat (3) @(negedge clk);
      check("R1", 6'b000000);               // reset state
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 6'b000000);               // idle after reset
      for (int a = 0; a < 8; a++) begin
         for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 4; c++) begin
               for (int m = 0; m < 1024; m++) begin
                  f              = 10'(m);
                  req_valid      = 1'b1;
                  req_addr       = pick_addr(a);
                  req_fetch      = k[0];
                  req_cpl        = 2'(c);
                  req_sys        = f[0];
                  req_stack      = f[1];
                  req_nofault    = f[2];
                  req_short      = f[3];
                  cfg_enable     = f[4];
                  cfg_long       = f[5];
                  cfg_data_guard = f[6];
                  cfg_ac         = f[7];
                  cfg_five_level = f[8];
                  if (f[9]) req_addr[31:0] = 32'hFFFF_0000;
                  e = model(tag);
                  @(negedge clk);
                  check(tag, {1'b1, e});
               end
            end
         end
      end
      req_valid = 1'b0;
      @(negedge clk);
      check("R1", 6'b000000);               // output drops with valid
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule